// File: doc/BRIEF.md
# Text-Mode Character Fetch Pipeline

This block turns a character screen held in byte memory into a stream of coloured dots for a 640x480 text display with 80 columns. Each character cell is eight dot clocks wide. In the first three dot clocks of a cell the block makes three accesses in a fixed order. It reads the character code, then looks up one row of that character's bitmap in the font memory, then reads the attribute byte stored just after the code. At the last dot clock of the cell the glyph row and the attribute are handed to an output shifter. The shifter sends the row out one dot per clock, most significant bit first, during the next cell time.

Screen position comes in as horizontal and vertical dot counters from an external sync generator. The block keeps its own count of the scanline within the text row and of the byte address where the current text row starts. It sets both once per frame from a vertical scroll offset of 0 to 255 scanlines. A height select picks 16-line or 8-line glyphs. A two-bit font select picks one of four fonts. Both memories sit outside the block and answer in the same cycle the address is presented.

Top module: `txt_char_fetch`

## Requirements
- R1: While reset is held and in the first blanking cycle after it, `pix_valid`, `pix_color`, `ram_rd` and `rom_rd` are all 0.
- R2: Inside the active window (hpos < 640, vpos < 480), the cycle with hpos mod 8 = 0 asserts `ram_rd` alone, with `ram_addr` = row base + 2 x column (column = hpos / 8, address modulo 2^16). Phases 3 to 7 make no access.
- R3: At phase 1 of a cell, `rom_rd` is asserted alone and `rom_addr` = {font_sel in bits 13:12, character code read at phase 0 in bits 11:4, scanline-in-row in bits 3:0}.
- R4: At phase 2 of a cell, `ram_rd` is asserted alone, and `ram_addr` is one above the phase 0 address. That byte is the cell's attribute.
- R5: The dot for screen column x of a visible line appears on `pix_color` with `pix_valid` = 1 in the cycle where hpos = x + 8 on the same line. It uses glyph bit 7 - (x mod 8). A set bit outputs attribute bits 3:0 (foreground) and a clear bit outputs attribute bits 7:4 (background).
- R6: Outside the active window no memory access is made. In any cycle whose dot is not visible, `pix_valid` = 0 and `pix_color` = 0.
- R7: The scanline-in-row count counts to 15 when `tall` = 1 and to 7 when `tall` = 0. It advances at hpos = 640 of each visible line. On wrapping to 0, the row base increases by 160 bytes.
- R8: At hpos = 0 of vertical position 480, the scanline count is loaded with scroll mod height and the row base with (scroll / height) x 160. So the first visible line starts there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hpos | input | 10 | Horizontal dot position |
| vpos | input | 10 | Vertical line position |
| tall | input | 1 | 1 = 16-line glyphs, 0 = 8-line glyphs |
| font_sel | input | 2 | Font bank select |
| scroll | input | 8 | Vertical scroll offset in scanlines |
| ram_rd | output | 1 | Screen memory read strobe |
| ram_addr | output | 16 | Screen memory byte address |
| ram_data | input | 8 | Screen memory read data, same cycle |
| rom_rd | output | 1 | Font memory read strobe |
| rom_addr | output | 14 | Font memory address |
| rom_data | input | 8 | Font memory row data, same cycle |
| pix_valid | output | 1 | Dot is inside the visible area |
| pix_color | output | 4 | Dot colour, 0 when not visible |

## Verification
The assertions assume that hpos counts up by one per clock within a line and that each line has at least eight blanking cycles after column 639. Without those, the phase 1 and phase 2 accesses would not follow a phase 0 access, and the address pointer would not be reloaded. They also assume that `tall` and `scroll` change only before the blanking line that starts a frame, so the scan bound holds at every line advance. The stimulus drives 656-cycle lines with counters that step by one. It changes configuration only between scenarios, and each scenario begins with a line at vertical position 480.

// File: rtl/txt_pkg.sv
package txt_pkg;
  localparam int CODE_W = 8;
  localparam int SCAN_W = 4;
  localparam int FONT_W = 2;
  localparam int ATTR_W = 8;
  localparam int CLR_W  = ATTR_W / 2;
  localparam int SCRL_W = 8;
  localparam int ROWI_W = SCRL_W - 3;
  localparam int ROM_AW = FONT_W + CODE_W + SCAN_W;

  typedef enum logic [2:0] {
    PH_CHR = 3'd0,
    PH_GLY = 3'd1,
    PH_COL = 3'd2
  } slot_ph_e;

  // highest scanline index inside a text row
  function automatic logic [SCAN_W-1:0] last_scan(input logic tall);
    return tall ? SCAN_W'(15) : SCAN_W'(7);
  endfunction

  // scanline-in-row that a scroll offset starts on
  function automatic logic [SCAN_W-1:0] first_scan(input logic tall,
                                                    input logic [SCRL_W-1:0] scroll);
    return tall ? scroll[3:0] : {1'b0, scroll[2:0]};
  endfunction

  // text row that a scroll offset starts on
  function automatic logic [ROWI_W-1:0] first_row(input logic tall,
                                                   input logic [SCRL_W-1:0] scroll);
    return tall ? {1'b0, scroll[SCRL_W-1:4]} : scroll[SCRL_W-1:3];
  endfunction

  function automatic logic [ROM_AW-1:0] glyph_addr(input logic [FONT_W-1:0] font,
                                                    input logic [CODE_W-1:0] code,
                                                    input logic [SCAN_W-1:0] scan);
    return {font, code, scan};
  endfunction

  function automatic logic [CLR_W-1:0] dot_color(input logic dot,
                                                  input logic [ATTR_W-1:0] attr);
    return dot ? attr[CLR_W-1:0] : attr[ATTR_W-1:CLR_W];
  endfunction
endpackage

// File: rtl/txt_slot_seq.sv
module txt_slot_seq
  import txt_pkg::*;
#(
  parameter int POS_W    = 10,
  parameter int H_ACTIVE = 640,
  parameter int V_ACTIVE = 480,
  parameter int GLYPH_W  = 8
) (
  input  logic [POS_W-1:0] hpos,
  input  logic [POS_W-1:0] vpos,
  output logic             active,
  output logic             slot_chr,
  output logic             slot_gly,
  output logic             slot_col,
  output logic             slot_load,
  output logic             line_adv,
  output logic             frame_init
);
  localparam int PH_W = $clog2(GLYPH_W);

  logic            h_in;
  logic            v_in;
  logic [PH_W-1:0] ph;

  assign h_in   = hpos < POS_W'(H_ACTIVE);
  assign v_in   = vpos < POS_W'(V_ACTIVE);
  assign active = h_in && v_in;
  assign ph     = hpos[PH_W-1:0];

  assign slot_chr  = active && (ph == PH_W'(PH_CHR));
  assign slot_gly  = active && (ph == PH_W'(PH_GLY));
  assign slot_col  = active && (ph == PH_W'(PH_COL));
  assign slot_load = active && (ph == PH_W'(GLYPH_W - 1));

  // first blanking dot of a visible line: step to the next scanline
  assign line_adv   = (hpos == POS_W'(H_ACTIVE)) && v_in;
  // first dot of the first blanking line: reload from scroll offset
  assign frame_init = (hpos == '0) && (vpos == POS_W'(V_ACTIVE));
endmodule

// File: rtl/txt_line_ctr.sv
module txt_line_ctr
  import txt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int COLS   = 80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tall,
  input  logic [SCRL_W-1:0] scroll,
  input  logic              line_adv,
  input  logic              frame_init,
  input  logic              active,
  input  logic              step,
  output logic [SCAN_W-1:0] scan,
  output logic [ADDR_W-1:0] row_base,
  output logic [ADDR_W-1:0] rd_ptr
);
  localparam logic [ADDR_W-1:0] ROW_STEP = ADDR_W'(2 * COLS);

  logic [ADDR_W-1:0] init_base;
  logic              wrap;

  assign init_base = ADDR_W'(first_row(tall, scroll)) * ROW_STEP;
  assign wrap      = scan == last_scan(tall);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scan     <= '0;
      row_base <= '0;
      rd_ptr   <= '0;
    end else begin
      if (frame_init) begin
        scan     <= first_scan(tall, scroll);
        row_base <= init_base;
      end else if (line_adv) begin
        if (wrap) begin
          scan     <= '0;
          row_base <= row_base + ROW_STEP;
        end else begin
          scan <= scan + 1'b1;
        end
      end

      if (step) begin
        rd_ptr <= rd_ptr + 1'b1;
      end else if (!active) begin
        rd_ptr <= row_base;
      end
    end
  end
endmodule

// File: rtl/txt_pix_shift.sv
module txt_pix_shift
  import txt_pkg::*;
#(
  parameter int GLYPH_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ATTR_W-1:0]  ram_data,
  input  logic [GLYPH_W-1:0] rom_data,
  input  logic               slot_chr,
  input  logic               slot_gly,
  input  logic               slot_col,
  input  logic               slot_load,
  input  logic               active,
  output logic [CODE_W-1:0]  char_code,
  output logic               pix_valid,
  output logic [CLR_W-1:0]   pix_color
);
  logic [ATTR_W-1:0]  hold;
  logic [ATTR_W-1:0]  attr;
  logic [GLYPH_W-1:0] glyph;
  logic [GLYPH_W-1:0] shreg;
  logic [GLYPH_W-1:0] act_pipe;

  // one holding register serves the code, then the attribute
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold  <= '0;
      glyph <= '0;
      attr  <= '0;
      shreg <= '0;
    end else begin
      if (slot_chr || slot_col) hold <= ram_data;
      if (slot_gly) glyph <= rom_data;
      if (slot_load) begin
        shreg <= glyph;
        attr  <= hold;
      end else begin
        shreg <= {shreg[GLYPH_W-2:0], 1'b0};
      end
    end
  end

  // visibility delayed by one cell time to line up with the shifter
  for (genvar i = 0; i < GLYPH_W; i++) begin : g_dly
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) act_pipe[0] <= 1'b0;
        else        act_pipe[0] <= active;
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (!rst_n) act_pipe[i] <= 1'b0;
        else        act_pipe[i] <= act_pipe[i-1];
      end
    end
  end

  assign char_code = hold[CODE_W-1:0];
  assign pix_valid = act_pipe[GLYPH_W-1];
  assign pix_color = pix_valid ? dot_color(shreg[GLYPH_W-1], attr) : '0;
endmodule

// File: rtl/txt_char_fetch.sv
module txt_char_fetch
  import txt_pkg::*;
#(
  parameter int POS_W    = 10,
  parameter int COLS     = 80,
  parameter int V_ACTIVE = 480,
  parameter int ADDR_W   = 16,
  parameter int GLYPH_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [POS_W-1:0]   hpos,
  input  logic [POS_W-1:0]   vpos,
  input  logic               tall,
  input  logic [FONT_W-1:0]  font_sel,
  input  logic [SCRL_W-1:0]  scroll,
  output logic               ram_rd,
  output logic [ADDR_W-1:0]  ram_addr,
  input  logic [ATTR_W-1:0]  ram_data,
  output logic               rom_rd,
  output logic [ROM_AW-1:0]  rom_addr,
  input  logic [GLYPH_W-1:0] rom_data,
  output logic               pix_valid,
  output logic [CLR_W-1:0]   pix_color
);
  localparam int H_ACTIVE = COLS * GLYPH_W;

  logic              active;
  logic              slot_chr;
  logic              slot_gly;
  logic              slot_col;
  logic              slot_load;
  logic              line_adv;
  logic              frame_init;
  logic [SCAN_W-1:0] scan_now;
  logic [ADDR_W-1:0] row_base;
  logic [ADDR_W-1:0] rd_ptr;
  logic [CODE_W-1:0] char_code;

  txt_slot_seq #(
    .POS_W   (POS_W),
    .H_ACTIVE(H_ACTIVE),
    .V_ACTIVE(V_ACTIVE),
    .GLYPH_W (GLYPH_W)
  ) u_seq (
    .hpos      (hpos),
    .vpos      (vpos),
    .active    (active),
    .slot_chr  (slot_chr),
    .slot_gly  (slot_gly),
    .slot_col  (slot_col),
    .slot_load (slot_load),
    .line_adv  (line_adv),
    .frame_init(frame_init)
  );

  txt_line_ctr #(
    .ADDR_W(ADDR_W),
    .COLS  (COLS)
  ) u_line (
    .clk       (clk),
    .rst_n     (rst_n),
    .tall      (tall),
    .scroll    (scroll),
    .line_adv  (line_adv),
    .frame_init(frame_init),
    .active    (active),
    .step      (slot_chr || slot_col),
    .scan      (scan_now),
    .row_base  (row_base),
    .rd_ptr    (rd_ptr)
  );

  txt_pix_shift #(
    .GLYPH_W(GLYPH_W)
  ) u_pix (
    .clk      (clk),
    .rst_n    (rst_n),
    .ram_data (ram_data),
    .rom_data (rom_data),
    .slot_chr (slot_chr),
    .slot_gly (slot_gly),
    .slot_col (slot_col),
    .slot_load(slot_load),
    .active   (active),
    .char_code(char_code),
    .pix_valid(pix_valid),
    .pix_color(pix_color)
  );

  assign ram_rd   = slot_chr || slot_col;
  assign ram_addr = rd_ptr;
  assign rom_rd   = slot_gly;
  assign rom_addr = glyph_addr(font_sel, char_code, scan_now);
endmodule

// File: rtl/txt_char_fetch_chk.sv
module txt_char_fetch_chk
  import txt_pkg::*;
#(
  parameter int POS_W    = 10,
  parameter int H_ACTIVE = 640,
  parameter int V_ACTIVE = 480,
  parameter int ADDR_W   = 16,
  parameter int COLS     = 80
) (
  input logic              clk,
  input logic              rst_n,
  input logic [POS_W-1:0]  hpos,
  input logic [POS_W-1:0]  vpos,
  input logic              tall,
  input logic              ram_rd,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              rom_rd,
  input logic              line_adv,
  input logic [SCAN_W-1:0] scan,
  input logic [ADDR_W-1:0] row_base
);
  localparam logic [ADDR_W-1:0] ROW_STEP = ADDR_W'(2 * COLS);

  // R3: the font lookup comes straight after a lone code read
  a_r3_glyph_after_char: assert property (@(posedge clk) disable iff (!rst_n)
    rom_rd |-> ($past(ram_rd) && !ram_rd));

  // R4: the attribute address is one above the code address
  a_r4_attr_next_byte: assert property (@(posedge clk) disable iff (!rst_n)
    rom_rd |-> (ram_addr == $past(ram_addr) + ADDR_W'(1)));

  // R4: the attribute read follows the font lookup at that address
  a_r4_attr_slot: assert property (@(posedge clk) disable iff (!rst_n)
    rom_rd |=> (ram_rd && $stable(ram_addr)));

  // R6: accesses only inside the visible window
  a_r6_fetch_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_rd || rom_rd) |-> (hpos < POS_W'(H_ACTIVE) && vpos < POS_W'(V_ACTIVE)));

  // R7: scan count stays within the glyph height
  a_r7_scan_bound: assert property (@(posedge clk) disable iff (!rst_n)
    line_adv |-> (scan <= (tall ? SCAN_W'(15) : SCAN_W'(7))));

  // R7: wrapping the scan count steps the row base by one text row
  a_r7_row_step: assert property (@(posedge clk) disable iff (!rst_n)
    (line_adv && scan == (tall ? SCAN_W'(15) : SCAN_W'(7))) |=>
      (scan == '0 && row_base == $past(row_base) + ROW_STEP));
endmodule

bind txt_char_fetch txt_char_fetch_chk #(
  .POS_W   (POS_W),
  .H_ACTIVE(H_ACTIVE),
  .V_ACTIVE(V_ACTIVE),
  .ADDR_W  (ADDR_W),
  .COLS    (COLS)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .hpos    (hpos),
  .vpos    (vpos),
  .tall    (tall),
  .ram_rd  (ram_rd),
  .ram_addr(ram_addr),
  .rom_rd  (rom_rd),
  .line_adv(line_adv),
  .scan    (scan_now),
  .row_base(row_base)
);

// File: tb/txt_char_fetch_bench.sv
`timescale 1ns/1ps
module txt_char_fetch_bench;
  localparam int LINE  = 656;
  localparam int H_ACT = 640;
  localparam int V_ACT = 480;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  hpos = 10'd640;
  logic [9:0]  vpos = 10'd480;
  logic        tall = 1'b1;
  logic [1:0]  font_sel = 2'd0;
  logic [7:0]  scroll = 8'd0;
  logic [7:0]  seed = 8'd0;
  logic        ram_rd;
  logic [15:0] ram_addr;
  logic [7:0]  ram_data;
  logic        rom_rd;
  logic [13:0] rom_addr;
  logic [7:0]  rom_data;
  logic        pix_valid;
  logic [3:0]  pix_color;

  int n_checks = 0;
  int n_fail = 0;
  int line_n = 0;
  int first_addr = 0;
  int first_scan = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  function automatic logic [7:0] ram_fn(input logic [15:0] a, input logic [7:0] s);
    return a[7:0] ^ {a[12:8], a[15:13]} ^ s;
  endfunction

  function automatic logic [7:0] rom_fn(input logic [13:0] a, input logic [7:0] s);
    logic [7:0] t;
    t = 8'(a[7:0] * 8'd29);
    return t ^ {a[13:8], 2'b10} ^ {s[3:0], s[7:4]};
  endfunction

  assign ram_data = ram_fn(ram_addr, seed);
  assign rom_data = rom_fn(rom_addr, seed);

  txt_char_fetch u_txt_char_fetch (
    .clk(clk), .rst_n(rst_n), .hpos(hpos), .vpos(vpos), .tall(tall),
    .font_sel(font_sel), .scroll(scroll),
    .ram_rd(ram_rd), .ram_addr(ram_addr), .ram_data(ram_data),
    .rom_rd(rom_rd), .rom_addr(rom_addr), .rom_data(rom_data),
    .pix_valid(pix_valid), .pix_color(pix_color)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive one full line and compare every cycle against the model
  task automatic run_line(input int v);
    bit act_line;
    int hgt, eff, sc, base;
    bit ok2 = 1, ok3 = 1, ok4 = 1, ok5 = 1, ok6 = 1;
    int a2 = 0, e2 = 0, a3 = 0, e3 = 0, a4 = 0, e4 = 0, a5 = 0, e5 = 0, a6 = 0, e6 = 0;
    act_line = v < V_ACT;
    hgt  = tall ? 16 : 8;
    eff  = int'(scroll) + line_n;
    sc   = eff % hgt;
    base = ((eff / hgt) * 160) % 65536;
    for (int h = 0; h < LINE; h++) begin
      @(posedge clk); #1;
      hpos = 10'(h);
      vpos = 10'(v);
      @(negedge clk);
      if (h == 0) first_addr = int'(ram_addr);
      if (h == 1) first_scan = int'(rom_addr[3:0]);
      if (act_line && h < H_ACT) begin
        int c, ph, ca, ea;
        c  = h / 8;
        ph = h % 8;
        ca = (base + 2 * c) % 65536;
        if (ph == 0) begin
          if (!(ram_rd && !rom_rd && int'(ram_addr) == ca) && ok2) begin
            ok2 = 0; a2 = int'(ram_addr); e2 = ca;
          end
        end else if (ph == 1) begin
          ea = (int'(font_sel) << 12) | (int'(ram_fn(16'(ca), seed)) << 4) | sc;
          if (!(rom_rd && !ram_rd && int'(rom_addr) == ea) && ok3) begin
            ok3 = 0; a3 = int'(rom_addr); e3 = ea;
          end
        end else if (ph == 2) begin
          ea = (ca + 1) % 65536;
          if (!(ram_rd && !rom_rd && int'(ram_addr) == ea) && ok4) begin
            ok4 = 0; a4 = int'(ram_addr); e4 = ea;
          end
        end else begin
          if ((ram_rd || rom_rd) && ok2) begin
            ok2 = 0; a2 = {ram_rd, rom_rd}; e2 = 0;
          end
        end
      end else if ((ram_rd || rom_rd) && ok6) begin
        ok6 = 0; a6 = {ram_rd, rom_rd}; e6 = 0;
      end
      if (act_line && h >= 8 && h < H_ACT + 8) begin
        int x, c, b, ca;
        logic [7:0] ch, at, g;
        logic [3:0] ec;
        x  = h - 8;
        c  = x / 8;
        b  = x % 8;
        ca = (base + 2 * c) % 65536;
        ch = ram_fn(16'(ca), seed);
        at = ram_fn(16'(ca + 1), seed);
        g  = rom_fn({font_sel, ch, 4'(sc)}, seed);
        ec = g[7 - b] ? at[3:0] : at[7:4];
        if (!(pix_valid && pix_color == ec) && ok5) begin
          ok5 = 0; a5 = {pix_valid, pix_color}; e5 = {1'b1, ec};
        end
      end else if ((pix_valid || pix_color != 4'd0) && ok6) begin
        ok6 = 0; a6 = {pix_valid, pix_color}; e6 = 0;
      end
    end
    if (act_line) begin
      chk(ok2, "R2", $sformatf("code read slot line %0d", v), a2, e2);
      chk(ok3, "R3", $sformatf("font lookup slot line %0d", v), a3, e3);
      chk(ok4, "R4", $sformatf("attribute slot line %0d", v), a4, e4);
      chk(ok5, "R5", $sformatf("dot stream line %0d", v), a5, e5);
      chk(first_addr == base && first_scan == sc, "R7",
          $sformatf("row base and scan line %0d", v),
          (first_addr << 4) | first_scan, (base << 4) | sc);
      line_n++;
    end
    chk(ok6, "R6", $sformatf("blank quiet line %0d", v), a6, e6);
    if (v == V_ACT) line_n = 0;
  endtask

  task automatic t_reset;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!pix_valid && pix_color == 0 && !ram_rd && !rom_rd, "R1", "held in reset",
        {ram_rd, rom_rd, pix_valid, pix_color}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!pix_valid && pix_color == 0 && !ram_rd && !rom_rd, "R1", "after release",
        {ram_rd, rom_rd, pix_valid, pix_color}, 0);
  endtask

  task automatic t_tall_rows;
    tall = 1'b1; font_sel = 2'd0; scroll = 8'd0; seed = 8'h00;
    run_line(V_ACT);
    for (int v = 0; v < 18; v++) run_line(v);  // R7: wraps after line 15
  endtask

  task automatic t_short_font;
    tall = 1'b0; font_sel = 2'd2; scroll = 8'd0; seed = 8'h5A;
    run_line(V_ACT);
    for (int v = 0; v < 10; v++) run_line(v);  // R7: wraps after line 7
  endtask

  task automatic t_scroll_tall;
    tall = 1'b1; font_sel = 2'd3; scroll = 8'd37; seed = 8'hC3;
    run_line(V_ACT);
    run_line(0);
    chk(first_addr == 320 && first_scan == 5, "R8", "scroll 37 tall start",
        (first_addr << 4) | first_scan, (320 << 4) | 5);
    for (int v = 1; v < 14; v++) run_line(v);
  endtask

  task automatic t_scroll_short;
    tall = 1'b0; font_sel = 2'd1; scroll = 8'd255; seed = 8'h96;
    run_line(V_ACT);
    run_line(0);
    chk(first_addr == 4960 && first_scan == 7, "R8", "scroll 255 short start",
        (first_addr << 4) | first_scan, (4960 << 4) | 7);
    run_line(1);
  endtask

  task automatic t_vblank;
    tall = 1'b1; font_sel = 2'd0; scroll = 8'd3; seed = 8'h21;
    run_line(500);  // R6: whole line below the visible area
    run_line(V_ACT);
    for (int v = 0; v < 3; v++) run_line(v);
  endtask

  initial begin
    t_reset();
    t_tall_rows();
    t_short_font();
    t_scroll_tall();
    t_scroll_short();
    t_vblank();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule